// File: doc/BRIEF.md
# Bypassable Programmable Clock Divider

This block derives one configurable clock from a source clock by integer division and can hand the output over to a reference clock at any time. Everything runs in the source clock domain. The reference clock arrives as a one-cycle enable pulse per reference period together with its level, both already sampled into the source domain. The output is a registered clock-enable pulse that marks the start of each output period, plus a registered level that carries the duty cycle. Switching between the divider and the reference is a choice of which enable and level feed the output registers, so no runt pulse can appear.

Software programs the block through a write strobe that carries a requested divisor and a bypass bit. A divisor change is wrapped in a protection window. The output is forced onto the reference, and the new divisor takes hold at the divider's next period boundary. The window is released only after a parameterised number of reference periods has passed and the new divisor is in force. Writes that arrive while the window is open are dropped. The block also takes a parent bypass flag, so it can be chained under another divider. When the parent runs from the reference, this block divides the reference pulses instead of the source cycles.

Top module: `clkdiv_bypass`

## Requirements
- R1: During and right after reset, out_en_o, out_lvl_o, byp_o and busy_o are 0, and the divisor is RST_DIV (default 2).
- R2: With byp_o and parent_byp_i both low, out_en_o pulses once every N source cycles, where N is the programmed divisor.
- R3: Within each output period, out_lvl_o is high for ceil(N/2) cycles starting at the out_en_o pulse: half the period for even N, one cycle more than low for odd N.
- R4: A stored divisor code of 0 means N = 256. A request of 0 or of 256 or more is stored as code 0, so requests above 256 saturate to division by 256.
- R5: With N = 1, out_en_o is high on every cycle and out_lvl_o stays high.
- R6: While byp_o is high, out_en_o and out_lvl_o equal ref_en_i and ref_lvl_i from the previous cycle, whatever the divisor.
- R7: A write whose clamped divisor differs from the stored one raises busy_o and byp_o on the next cycle. They stay high until at least SETTLE_REFS reference pulses have been seen and the new divisor has taken effect at a period boundary. Then busy_o falls, and byp_o follows the stored bypass bit.
- R8: A write strobe while busy_o is high is ignored entirely.
- R9: A write with an unchanged divisor opens no window (busy_o stays 0) and only updates the bypass bit.
- R10: While parent_byp_i is high, the divider counts reference pulses instead of source cycles, so the output period is N reference periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_en_i | input | 1 | One-cycle pulse per reference clock period |
| ref_lvl_i | input | 1 | Reference clock level, sampled in the source domain |
| parent_byp_i | input | 1 | Parent clock is bypassed; count reference pulses |
| wr_stb_i | input | 1 | Write strobe for divisor and bypass bit |
| wr_div_i | input | REQ_W | Requested divisor (0 or >=256 gives 256) |
| wr_byp_i | input | 1 | Software bypass bit |
| out_en_o | output | 1 | Clock-enable pulse at the start of each output period |
| out_lvl_o | output | 1 | Output clock level |
| byp_o | output | 1 | Output currently follows the reference |
| busy_o | output | 1 | Divisor change window open; writes ignored |

## Verification
The main function is exercised with a sweep of requested divisors: 1, small even and odd values, an over-range request, exactly 256, and 0. The measured period separates correct counting and clamping from wrap-around errors, and the high-phase count separates the even-duty rule from the odd-duty rule. Bypass is tried with an unchanged divisor, which must show the reference period and open no window. Further cases cover a changed divisor, whose window length is measured against the settle count; a write issued inside the window, which must leave the earlier divisor in force; and a parent bypass, which must stretch the period by the reference period.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_st_e;
endpackage

// File: rtl/cdb_div_core.sv
module cdb_div_core #(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] RST_CODE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] tgt_code_i,
  output logic             div_en_o,
  output logic             div_lvl_o,
  output logic             aligned_o
);
  localparam int CNT_W = DIV_W + 1;
  localparam int MAX_N = 1 << DIV_W;

  function automatic logic [CNT_W-1:0] decode(input logic [DIV_W-1:0] code);
    if (code == '0) decode = CNT_W'(MAX_N);
    else            decode = {1'b0, code};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_n_q;
  logic [CNT_W-1:0] tgt_n;
  logic [CNT_W-1:0] hi_len;
  logic             last;

  assign tgt_n  = decode(tgt_code_i);
  assign hi_len = (cur_n_q + 1'b1) >> 1;
  assign last   = (cnt_q == cur_n_q - 1'b1);

  // The divisor in force changes only when a period ends.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cur_n_q <= decode(RST_CODE);
    end else if (tick_i) begin
      if (last) begin
        cnt_q   <= '0;
        cur_n_q <= tgt_n;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign div_en_o  = tick_i && (cnt_q == '0);
  assign div_lvl_o = (cnt_q < hi_len);
  assign aligned_o = (cur_n_q == tgt_n);
endmodule

// File: rtl/cdb_seq.sv
module cdb_seq
  import cdb_pkg::*;
#(
  parameter int SETTLE_REFS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ref_en_i,
  input  logic aligned_i,
  output logic busy_o
);
  localparam int W = $clog2(SETTLE_REFS + 1);
  localparam logic [W-1:0] DONE = W'(SETTLE_REFS);

  seq_st_e      st_q;
  logic [W-1:0] wcnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (start_i) begin
            st_q   <= SEQ_HOLD;
            wcnt_q <= '0;
          end
        end
        default: begin
          if ((wcnt_q == DONE) && aligned_i) st_q <= SEQ_IDLE;
          else if (ref_en_i && (wcnt_q != DONE)) wcnt_q <= wcnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (st_q == SEQ_HOLD);
endmodule

// File: rtl/clkdiv_bypass.sv
module clkdiv_bypass #(
  parameter int DIV_W       = 8,
  parameter int REQ_W       = 12,
  parameter int SETTLE_REFS = 4,
  parameter int RST_DIV     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic             ref_lvl_i,
  input  logic             parent_byp_i,
  input  logic             wr_stb_i,
  input  logic [REQ_W-1:0] wr_div_i,
  input  logic             wr_byp_i,
  output logic             out_en_o,
  output logic             out_lvl_o,
  output logic             byp_o,
  output logic             busy_o
);
  localparam int MAX_N = 1 << DIV_W;
  localparam logic [DIV_W-1:0] RST_CODE = DIV_W'(RST_DIV % MAX_N);

  logic [DIV_W-1:0] req_code;
  logic [DIV_W-1:0] code_q;
  logic             sw_byp_q;
  logic             accept, start;
  logic             tick, div_en, div_lvl, aligned, busy;
  logic             en_q, lvl_q;

  // Clamp: 0 and anything at or above the top divisor become code 0.
  always_comb begin
    if ((wr_div_i == '0) || (wr_div_i >= REQ_W'(MAX_N))) req_code = '0;
    else req_code = wr_div_i[DIV_W-1:0];
  end

  assign accept = wr_stb_i && !busy;
  assign start  = accept && (req_code != code_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      code_q   <= RST_CODE;
      sw_byp_q <= 1'b0;
    end else if (accept) begin
      code_q   <= req_code;
      sw_byp_q <= wr_byp_i;
    end
  end

  assign tick = parent_byp_i ? ref_en_i : 1'b1;

  cdb_div_core #(.DIV_W(DIV_W), .RST_CODE(RST_CODE)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .tgt_code_i (code_q),
    .div_en_o   (div_en),
    .div_lvl_o  (div_lvl),
    .aligned_o  (aligned)
  );

  cdb_seq #(.SETTLE_REFS(SETTLE_REFS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .ref_en_i  (ref_en_i),
    .aligned_i (aligned),
    .busy_o    (busy)
  );

  assign byp_o  = sw_byp_q | busy;
  assign busy_o = busy;

  // Output select happens into registers, never on a clock net.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      en_q  <= byp_o ? ref_en_i  : div_en;
      lvl_q <= byp_o ? ref_lvl_i : div_lvl;
    end
  end

  assign out_en_o  = en_q;
  assign out_lvl_o = lvl_q;
endmodule

// File: rtl/cdb_chk.sv
module cdb_chk #(
  parameter int SETTLE_REFS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_en_i,
  input logic ref_lvl_i,
  input logic parent_byp_i,
  input logic wr_stb_i,
  input logic out_en_o,
  input logic out_lvl_o,
  input logic byp_o,
  input logic busy_o
);
  int refs_seen;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !busy_o) refs_seen <= 0;
    else if (ref_en_i && refs_seen < SETTLE_REFS + 1) refs_seen <= refs_seen + 1;
  end

  assert_ref_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_o |=> (out_en_o == $past(ref_en_i)) && (out_lvl_o == $past(ref_lvl_i)));

  assert_window_from_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_stb_i));

  assert_settle_length_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (refs_seen >= SETTLE_REFS));

  assert_no_tick_no_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_o && parent_byp_i && !ref_en_i) |=> !out_en_o);
endmodule

bind clkdiv_bypass cdb_chk #(.SETTLE_REFS(SETTLE_REFS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_en_i     (ref_en_i),
  .ref_lvl_i    (ref_lvl_i),
  .parent_byp_i (parent_byp_i),
  .wr_stb_i     (wr_stb_i),
  .out_en_o     (out_en_o),
  .out_lvl_o    (out_lvl_o),
  .byp_o        (byp_o),
  .busy_o       (busy_o)
);

// File: tb/sim_clkdiv_bypass.sv
`timescale 1ns/1ps
module sim_clkdiv_bypass;
  localparam int REQ_W   = 12;
  localparam int SETTLE  = 4;
  localparam int REF_PER = 5;
  localparam int NV      = 9;
  localparam int GUARD   = 3000;

  localparam logic [REQ_W-1:0] VREQ [NV] = '{12'd1, 12'd2, 12'd3, 12'd5, 12'd8, 12'd300, 12'd256, 12'd0, 12'd7};
  localparam int VPER [NV] = '{1, 2, 3, 5, 8, 256, 256, 256, 7};
  localparam int VHI  [NV] = '{1, 1, 2, 3, 4, 128, 128, 128, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0, ref_lvl = 1'b0, parent_byp = 1'b0;
  logic wr_stb = 1'b0, wr_byp = 1'b0;
  logic [REQ_W-1:0] wr_div = '0;
  logic out_en, out_lvl, byp, busy;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  clkdiv_bypass #(.REQ_W(REQ_W), .SETTLE_REFS(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .ref_lvl_i(ref_lvl),
    .parent_byp_i(parent_byp), .wr_stb_i(wr_stb), .wr_div_i(wr_div), .wr_byp_i(wr_byp),
    .out_en_o(out_en), .out_lvl_o(out_lvl), .byp_o(byp), .busy_o(busy));

  initial begin : refgen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == REF_PER - 1) ? 0 : ph + 1;
      ref_en  = (ph == 0);
      ref_lvl = (ph <= 1);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    nchk++;
    if (act < lim) begin
      nfail++;
      $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
    end
  endtask

  task automatic write(input logic [REQ_W-1:0] d, input logic b);
    @(negedge clk);
    wr_stb = 1'b1; wr_div = d; wr_byp = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < GUARD) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic wait_pulse;
    int g;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!out_en && g < GUARD);
  endtask

  // Skip one pulse, then measure one full period and its high cycles.
  task automatic measure(output int per, output int hi);
    wait_pulse();
    wait_pulse();
    per = 0; hi = 0;
    do begin
      hi += int'(out_lvl);
      per++;
      @(negedge clk);
    end while (!out_en && per < GUARD);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int per, hi, cyc;
    repeat (3) @(negedge clk);
    chk("R1 out_en in reset", int'(out_en), 0);
    chk("R1 out_lvl in reset", int'(out_lvl), 0);
    chk("R1 byp in reset", int'(byp), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    measure(per, hi);
    chk("R1 reset divisor period", per, 2);

    // Divisor sweep: R2 period, R3 duty, R4 clamp and code 0, R5 divide by 1
    for (int i = 0; i < NV; i++) begin
      write(VREQ[i], 1'b0);
      wait_idle(cyc);
      measure(per, hi);
      chk($sformatf("R2/R4 period req %0d", VREQ[i]), per, VPER[i]);
      chk($sformatf("R3/R5 high cycles req %0d", VREQ[i]), hi, VHI[i]);
    end

    // R9 and R6: same divisor (7) with bypass set; no window, reference out
    write(12'd7, 1'b1);
    chk("R9 no window on same divisor", int'(busy), 0);
    chk("R6 byp_o set by bypass bit", int'(byp), 1);
    measure(per, hi);
    chk("R6 bypass period follows reference", per, REF_PER);
    chk("R6 bypass high follows reference", hi, 2);
    write(12'd7, 1'b0);
    chk("R9 bypass released without window", int'(byp) + int'(busy), 0);

    // R7: changed divisor opens a timed bypass window
    write(12'd4, 1'b0);
    chk("R7 busy after change", int'(busy), 1);
    chk("R7 byp_o after change", int'(byp), 1);
    wait_idle(cyc);
    chk_ge("R7 window length", cyc + 1, (SETTLE - 1) * REF_PER + 1);
    chk("R7 byp_o released", int'(byp), 0);
    measure(per, hi);
    chk("R7 new divisor in force", per, 4);

    // R8: a write during the window is dropped
    write(12'd3, 1'b0);
    @(negedge clk);
    wr_stb = 1'b1; wr_div = 12'd6; wr_byp = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    wait_idle(cyc);
    chk("R8 ignored write left bypass off", int'(byp), 0);
    measure(per, hi);
    chk("R8 ignored write left divisor 3", per, 3);

    // R10: parent bypassed, count reference pulses
    parent_byp = 1'b1;
    measure(per, hi);
    chk("R10 period in reference pulses", per, 3 * REF_PER);
    parent_byp = 1'b0;
    measure(per, hi);
    chk("R10 period back on source", per, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule